// File: doc/BRIEF.md
# Temperature Alert Controller

The block runs a periodic on-die temperature measurement and checks every reading against three programmable alert thresholds. Software reaches it through a small word-addressed register bus. Through that bus it sets a run enable, a measurement mode, a repeat schedule, per-channel thresholds and interrupt controls. It can read back the latest reading. Readings arrive from the sensor front end on a valid/ready stream.

Once the block is running, it pulses `meas_req` to ask the sensor for a conversion. The sensor answers with one 9-bit two's-complement sample in whole degrees Celsius. Each accepted sample updates the temperature register and is compared with every channel's threshold. A channel that trips latches a pending flag, and the combined level interrupt `irq` reports it.

Two timed windows are modelled:
- **Warm-up.** After the run enable is set, the block ignores the sensor for `STARTUP_CYC` cycles.
- **Lockout.** After the run enable is cleared, the block shows busy for `LOCKOUT_CYC` cycles and drops every register write.

A factory trim word selects between itself and a software setup register. A zero trim word picks the software setup register.

Stream rules: a sample transfers on a cycle with `smp_valid` and `smp_ready` both high. `smp_ready` is high only while the block is running in temperature mode past warm-up. The sensor must hold its sample while ready is low, and samples offered at other times are never taken.

Top module: `thermal_alert_ctrl`

Register map (byte addresses):

| Address | Register | Bits |
|---|---|---|
| 0x00 | run | bit 0 run enable; bit 8 busy (read-only) |
| 0x04 | mode | bits 3:0 mode |
| 0x08 | repeat | bit 24 endless; bits 3:0 period code |
| 0x0C | temperature | bits 8:0 reading (read-only) |
| 0x10 | interrupt control | 4 bits per channel (R6) |
| 0x14 | trim setup | see R11 |
| 0x20, 0x24, 0x28 | thresholds, channels 0, 1, 2 | see R4 |

## Requirements
- R1: After reset, every register reads 0. `irq`, `smp_ready` and `meas_req` are 0.
- R2: After the run bit (0x00 bit 0) is set with mode 5, `smp_ready` and `meas_req` stay 0 for `STARTUP_CYC` cycles. After that, `smp_ready` rises and one `meas_req` pulse is issued.
- R3: The temperature register (0x0C) holds the last accepted sample as a 9-bit two's-complement value in bits 8:0, and bits 31:9 read 0. It reads 0 from run enable until the first accepted sample.
- R4: Channels 0, 1 and 2 have threshold registers at 0x20, 0x24 and 0x28. Bits 23:16 hold an unsigned threshold in degrees Celsius and bit 0 holds the channel alert enable. All other bits read 0.
- R5: A channel's pending flag sets on an accepted sample whose signed value is greater than or equal to its threshold, provided the channel alert enable and its interrupt enable are both 1. The flag stays set until it is cleared.
- R6: In the interrupt control register (0x10), channel n uses bit 4n as its interrupt enable. Bit 4n+1 is its pending flag, which is read-only. Writing 1 to bit 4n+2 clears the pending flag, and that bit reads 0.
- R7: `irq` is the OR over channels of pending AND interrupt enable. Dropping an interrupt enable lowers `irq` but leaves the pending flag set.
- R8: With a mode other than 5, `smp_ready` and `meas_req` stay 0.
- R9: With the endless bit (0x08 bit 24) set, `meas_req` pulses every `PERIOD_UNIT << code` cycles, where code is 0x08 bits 3:0. With the bit clear, only one pulse follows warm-up.
- R10: After the run bit is cleared, busy (0x00 bit 8) reads 1 for `LOCKOUT_CYC` cycles and `smp_ready` is 0. Register writes in that time are ignored.
- R11: `trim_word` equals `fuse_coef` when that input is nonzero. Otherwise it equals the trim setup register (0x14), which keeps bits 30:0: a 14-bit value at 29:16 with its enable at 30, and a 15-bit value at 14:0 with its enable at 15.
- R12: A sample transfers only when `smp_valid` and `smp_ready` are both 1. A sample offered while ready is 0 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read strobe |
| smp_valid | input | 1 | Sensor sample valid |
| smp_ready | output | 1 | Block accepts a sample |
| smp_data | input | 9 | Signed sample, degrees Celsius |
| meas_req | output | 1 | One-cycle conversion request |
| fuse_coef | input | 32 | Factory trim word, zero when absent |
| trim_word | output | 32 | Selected trim word |
| irq | output | 1 | Combined alert interrupt |

## Verification
Each result falls due at a fixed number of cycles after its stimulus:
- A register read returns data on the clock edge after the strobe.
- A sample handshake updates the temperature register and the pending flags on that same edge, and `irq` follows combinationally.
- `smp_ready` rises `STARTUP_CYC` + 1 edges after the run write. Busy is visible from the edge of the clearing write.

The bench drives every input and reads every output at the falling edge, and allows a margin of several cycles around the warm-up and lockout boundaries. It counts `meas_req` pulses over whole windows that are multiples of the period.

// File: rtl/thm_pkg.sv
package thm_pkg;
  localparam int AW = 8;
  localparam int DW = 32;
  localparam int TW = 9;
  localparam logic [AW-1:0] A_RUN  = 8'h00;
  localparam logic [AW-1:0] A_MODE = 8'h04;
  localparam logic [AW-1:0] A_REP  = 8'h08;
  localparam logic [AW-1:0] A_TEMP = 8'h0C;
  localparam logic [AW-1:0] A_INT  = 8'h10;
  localparam logic [AW-1:0] A_TRIM = 8'h14;
  localparam logic [AW-1:0] A_THR0 = 8'h20;
  localparam logic [3:0]    MODE_TEMP = 4'h5;
  localparam logic [DW-1:0] TRIM_MASK = 32'h7FFF_FFFF;
  typedef enum logic [1:0] {S_IDLE, S_WARM, S_RUN, S_LOCK} seq_st_t;
endpackage

// File: rtl/thm_seq.sv
module thm_seq import thm_pkg::*; #(
  parameter int STARTUP_CYC = 35000,
  parameter int LOCKOUT_CYC = 50000,
  parameter int PERIOD_UNIT = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run_en,
  input  logic       mode_ok,
  input  logic       endless,
  input  logic [3:0] code,
  output logic       meas_req,
  output logic       active,
  output logic       warming,
  output logic       lock
);
  seq_st_t     st;
  logic [31:0] cnt;
  logic        req_q;
  logic [31:0] ival;

  assign ival = 32'(PERIOD_UNIT) << code;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      cnt   <= '0;
      req_q <= 1'b0;
    end else begin
      req_q <= 1'b0;
      case (st)
        S_IDLE: if (run_en) begin st <= S_WARM; cnt <= '0; end
        S_WARM: begin
          if (!run_en) begin st <= S_LOCK; cnt <= '0; end
          else if (cnt == 32'(STARTUP_CYC - 1)) begin
            st <= S_RUN; cnt <= '0; req_q <= 1'b1;
          end else cnt <= cnt + 32'd1;
        end
        S_RUN: begin
          if (!run_en) begin st <= S_LOCK; cnt <= '0; end
          else if (cnt == ival - 32'd1) begin cnt <= '0; req_q <= endless; end
          else cnt <= cnt + 32'd1;
        end
        default: begin
          if (cnt == 32'(LOCKOUT_CYC - 1)) begin st <= S_IDLE; cnt <= '0; end
          else cnt <= cnt + 32'd1;
        end
      endcase
    end
  end

  assign active   = (st == S_RUN) && run_en && mode_ok;
  assign meas_req = req_q && active;
  assign warming  = (st == S_WARM);
  assign lock     = (st == S_LOCK) || ((st != S_IDLE) && !run_en);

  // R2: no conversion request during warm-up
  p_no_req_warm_r2: assert property (@(posedge clk) disable iff (!rst_n)
    warming |-> !meas_req);
  // R10: lockout ends only in idle
  p_lock_to_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_LOCK) |=> (st == S_LOCK) || (st == S_IDLE));
endmodule

// File: rtl/thm_alert_ch.sv
module thm_alert_ch import thm_pkg::*; (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fire,
  input  logic [TW-1:0] smp,
  input  logic [7:0]    thr,
  input  logic          ch_en,
  input  logic          int_en,
  input  logic          clr,
  output logic          pend
);
  logic hit;
  assign hit = fire && ch_en && int_en &&
               ($signed({smp[TW-1], smp}) >= $signed({2'b00, thr}));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   pend <= 1'b0;
    else if (hit) pend <= 1'b1;
    else if (clr) pend <= 1'b0;
  end

  // R6: clear strobe empties the flag
  p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !hit) |=> !pend);
  // R5: flag is sticky
  p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !clr) |=> pend);
endmodule

// File: rtl/thermal_alert_ctrl.sv
module thermal_alert_ctrl import thm_pkg::*; #(
  parameter int NCH         = 3,
  parameter int STARTUP_CYC = 35000,
  parameter int LOCKOUT_CYC = 50000,
  parameter int PERIOD_UNIT = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_en,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          smp_valid,
  output logic          smp_ready,
  input  logic [TW-1:0] smp_data,
  output logic          meas_req,
  input  logic [DW-1:0] fuse_coef,
  output logic [DW-1:0] trim_word,
  output logic          irq
);
  logic          run_q, endless_q;
  logic [3:0]    mode_q, code_q;
  logic [TW-1:0] temp_q;
  logic [DW-1:0] trim_q, rd_mux, int_rd;
  logic [NCH-1:0] ien_q, chen_q, pend, clr;
  logic [7:0]    thr_q [NCH];
  logic          active, warming, lock, wr_ok, hs;

  assign wr_ok     = bus_en && bus_we && !lock;
  assign hs        = smp_valid && smp_ready;
  assign smp_ready = active;

  thm_seq #(.STARTUP_CYC(STARTUP_CYC), .LOCKOUT_CYC(LOCKOUT_CYC),
            .PERIOD_UNIT(PERIOD_UNIT)) u_seq (
    .clk(clk), .rst_n(rst_n), .run_en(run_q), .mode_ok(mode_q == MODE_TEMP),
    .endless(endless_q), .code(code_q), .meas_req(meas_req),
    .active(active), .warming(warming), .lock(lock));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0; mode_q <= '0; endless_q <= 1'b0; code_q <= '0;
      ien_q <= '0; trim_q <= '0; chen_q <= '0;
      for (int i = 0; i < NCH; i++) thr_q[i] <= '0;
    end else if (wr_ok) begin
      case (bus_addr)
        A_RUN:  run_q <= bus_wdata[0];
        A_MODE: mode_q <= bus_wdata[3:0];
        A_REP:  begin endless_q <= bus_wdata[24]; code_q <= bus_wdata[3:0]; end
        A_TRIM: trim_q <= bus_wdata & TRIM_MASK;
        A_INT:  for (int i = 0; i < NCH; i++) ien_q[i] <= bus_wdata[4*i];
        default: ;
      endcase
      for (int i = 0; i < NCH; i++)
        if (bus_addr == A_THR0 + 8'(4*i)) begin
          thr_q[i]  <= bus_wdata[23:16];
          chen_q[i] <= bus_wdata[0];
        end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       temp_q <= '0;
    else if (warming) temp_q <= '0;
    else if (hs)      temp_q <= smp_data;
  end

  genvar g;
  generate
    for (g = 0; g < NCH; g++) begin : g_ch
      assign clr[g] = wr_ok && (bus_addr == A_INT) && bus_wdata[4*g+2];
      thm_alert_ch u_ch (
        .clk(clk), .rst_n(rst_n), .fire(hs), .smp(smp_data), .thr(thr_q[g]),
        .ch_en(chen_q[g]), .int_en(ien_q[g]), .clr(clr[g]), .pend(pend[g]));
    end
  endgenerate

  assign irq       = |(pend & ien_q);
  assign trim_word = (fuse_coef != '0) ? fuse_coef : trim_q;

  always_comb begin
    int_rd = '0;
    for (int i = 0; i < NCH; i++) begin
      int_rd[4*i]   = ien_q[i];
      int_rd[4*i+1] = pend[i];
    end
  end

  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      A_RUN:  rd_mux = {23'b0, lock, 7'b0, run_q};
      A_MODE: rd_mux = {28'b0, mode_q};
      A_REP:  rd_mux = {7'b0, endless_q, 20'b0, code_q};
      A_TEMP: rd_mux = {23'b0, temp_q};
      A_INT:  rd_mux = int_rd;
      A_TRIM: rd_mux = trim_q;
      default: ;
    endcase
    for (int i = 0; i < NCH; i++)
      if (bus_addr == A_THR0 + 8'(4*i))
        rd_mux = {8'b0, thr_q[i], 15'b0, chen_q[i]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                bus_rdata <= '0;
    else if (bus_en && !bus_we) bus_rdata <= rd_mux;
  end

  // R10: run cannot be re-armed during lockout
  p_busy_norun_r10: assert property (@(posedge clk) disable iff (!rst_n)
    lock |=> !run_q);
  // R8: stream opens only in temperature mode
  p_ready_mode_r8: assert property (@(posedge clk) disable iff (!rst_n)
    smp_ready |-> (mode_q == MODE_TEMP));
  // R7: interrupt rises only after a sample or an interrupt-control write
  p_irq_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(hs || (wr_ok && bus_addr == A_INT)));
  // R3: reading changes only on a transfer or warm-up clear
  p_temp_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!hs && !warming) |=> $stable(temp_q));
endmodule

// File: tb/thermal_alert_ctrl_test.sv
`timescale 1ns/1ps
module thermal_alert_ctrl_test;
  localparam int SU = 20, LO = 30, PU = 2;
  localparam int NV = 10;
  // {sample[8:0], expected pending ch2..ch0}, thresholds 50/80/100
  localparam logic [11:0] VEC [NV] = '{
    {9'h000, 3'b000}, {9'h1FF, 3'b000}, {9'h031, 3'b000}, {9'h032, 3'b001},
    {9'h04F, 3'b001}, {9'h050, 3'b011}, {9'h064, 3'b111}, {9'h0FF, 3'b111},
    {9'h100, 3'b000}, {9'h063, 3'b011}};

  logic clk = 0, rst_n = 0;
  logic bus_en = 0, bus_we = 0;
  logic [7:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata, fuse_coef = 0, trim_word;
  logic smp_valid = 0, smp_ready, meas_req, irq;
  logic [8:0] smp_data = 0;
  int checks = 0, errors = 0, req_cnt = 0;

  always #10 clk = ~clk;

  thermal_alert_ctrl #(.STARTUP_CYC(SU), .LOCKOUT_CYC(LO), .PERIOD_UNIT(PU)) uut (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .smp_valid(smp_valid),
    .smp_ready(smp_ready), .smp_data(smp_data), .meas_req(meas_req),
    .fuse_coef(fuse_coef), .trim_word(trim_word), .irq(irq));

  always @(posedge clk) if (meas_req) req_cnt <= req_cnt + 1;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_en = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_en = 0; bus_we = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); bus_en = 1; bus_we = 0; bus_addr = a;
    @(negedge clk); bus_en = 0; d = bus_rdata;
  endtask

  task automatic send(input logic [8:0] v);
    @(negedge clk);
    while (!smp_ready) @(negedge clk);
    smp_valid = 1; smp_data = v;
    @(negedge clk); smp_valid = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d, e;
    int base;
    logic seen;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    @(negedge clk);
    chk("R1 irq", {31'b0, irq}, 0);
    chk("R1 ready", {31'b0, smp_ready}, 0);
    rd(8'h00, d); chk("R1 run reg", d, 0);
    rd(8'h0C, d); chk("R1 temp reg", d, 0);
    rd(8'h10, d); chk("R1 int reg", d, 0);
    // R4 threshold layout and masking
    wr(8'h24, 32'hFFAB_FF01);
    rd(8'h24, d); chk("R4 thr mask", d, 32'h00AB_0001);
    wr(8'h20, (32'd50 << 16) | 1);
    wr(8'h24, (32'd80 << 16) | 1);
    wr(8'h28, (32'd100 << 16) | 1);
    rd(8'h28, d); chk("R4 thr ch2", d, 32'h0064_0001);
    wr(8'h04, 32'h5);
    wr(8'h08, 32'h1);
    wr(8'h10, 32'h111);
    // R2 / R12 warm-up window
    base = req_cnt;
    wr(8'h00, 32'h1);
    smp_valid = 1; smp_data = 9'd77;
    seen = 0;
    for (int i = 0; i < SU - 2; i++) begin
      @(negedge clk);
      if (smp_ready) seen = 1;
    end
    smp_valid = 0;
    chk("R2 ready low in warm-up", {31'b0, seen}, 0);
    chk("R2 no request in warm-up", req_cnt - base, 0);
    repeat (5) @(negedge clk);
    chk("R2 ready after warm-up", {31'b0, smp_ready}, 1);
    repeat (40) @(negedge clk);
    chk("R9 single request", req_cnt - base, 1);
    rd(8'h0C, d); chk("R12 R3 dropped sample temp 0", d, 0);
    // R9 endless repeat
    wr(8'h08, 32'h0100_0001);
    repeat (5) @(negedge clk);
    base = req_cnt;
    repeat (40) @(negedge clk);
    chk("R9 endless period", req_cnt - base, 10);
    // R3 R5 R6 vector table
    for (int v = 0; v < NV; v++) begin
      wr(8'h10, 32'h555);
      send(VEC[v][11:3]);
      rd(8'h0C, d); chk("R3 temp reading", d, {23'b0, VEC[v][11:3]});
      e = 32'h111;
      for (int n = 0; n < 3; n++) if (VEC[v][n]) e |= 32'(1) << (4*n + 1);
      rd(8'h10, d); chk("R5 R6 pending", d, e);
      chk("R7 irq vector", {31'b0, irq}, {31'b0, |VEC[v][2:0]});
    end
    // R7 enable masking keeps pending
    wr(8'h10, 32'h555);
    send(9'd120);
    chk("R7 irq set", {31'b0, irq}, 1);
    wr(8'h10, 32'h000);
    chk("R7 irq masked", {31'b0, irq}, 0);
    rd(8'h10, d); chk("R7 pending kept", d, 32'h222);
    wr(8'h10, 32'h111);
    chk("R7 irq back", {31'b0, irq}, 1);
    wr(8'h10, 32'h555);
    chk("R6 clear drops irq", {31'b0, irq}, 0);
    rd(8'h10, d); chk("R6 clear reads 0", d, 32'h111);
    // R5 channel alert enable off
    wr(8'h28, (32'd100 << 16));
    send(9'd120);
    rd(8'h10, d); chk("R5 channel disabled", d, 32'h133);
    // R8 wrong mode
    wr(8'h04, 32'h3);
    repeat (2) @(negedge clk);
    base = req_cnt;
    repeat (40) @(negedge clk);
    chk("R8 no requests", req_cnt - base, 0);
    chk("R8 ready low", {31'b0, smp_ready}, 0);
    wr(8'h04, 32'h5);
    // R11 trim selection
    wr(8'h14, 32'hFFFF_FFFF);
    chk("R11 software trim", trim_word, 32'h7FFF_FFFF);
    fuse_coef = 32'h0000_1234;
    @(negedge clk);
    chk("R11 fuse trim", trim_word, 32'h0000_1234);
    // R10 lockout
    wr(8'h00, 32'h0);
    rd(8'h00, d); chk("R10 busy", d, 32'h100);
    wr(8'h04, 32'h3);
    chk("R10 ready low", {31'b0, smp_ready}, 0);
    repeat (LO + 5) @(negedge clk);
    rd(8'h00, d); chk("R10 busy ends", d, 0);
    rd(8'h04, d); chk("R10 write ignored", d, 32'h5);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule